// File: doc/BRIEF.md
# Radio Packet Bit-Stream Framer

This block turns one packet's worth of configuration and payload bytes into a serial bit stream for a short-range radio modulator. After a start pulse it emits, one bit per accepted enable strobe, a one-byte alternating preamble, a 3 to 5 byte address, an optional 9-bit control word, the payload bytes taken over a ready/valid byte port, and an optional 1 or 2 byte CRC. Every field goes out most significant bit first.

The preamble phase is chosen so that its last bit differs from the first address bit, which gives the receiver a clean alternating run into the address. The CRC covers everything after the preamble. It is appended when its enable bit is set, and also whenever auto-acknowledge or dynamic payload length is active, even with the enable bit clear. A start with an illegal payload length or address width is refused with a one-cycle reject pulse, and nothing is sent.

The modulator pulls bits with `bit_en`. A bit is consumed only on a cycle where both `tx_valid` and `bit_en` are high. While the framer waits for the next payload byte, `tx_valid` drops and the stream pauses.

Top module: `pkt_framer`

## Requirements
- R1: The first 8 bits sent are an alternating preamble. It is 10101010 when the first address bit is 1 and 01010101 when it is 0.
- R2: `addr_bytes` selects an address of 3, 4 or 5 bytes, taken from the low bytes of `addr`. The address is sent from `addr[8*addr_bytes-1]` down to bit 0. Any other width is refused with a reject pulse.
- R3: When `ctrl_en` is high, 9 control bits follow the address: `pay_len[5:0]` MSB first, then `pkt_id[1:0]` MSB first, then `no_ack`. When `ctrl_en` is low, the control bits are left out.
- R4: Exactly `pay_len` bytes are taken through the ready/valid port. They are sent in the order received, each MSB first. `pay_ready` is only high while a packet is in progress.
- R5: A start with `pay_len` of 0 or above 32 gives `reject` high for one cycle, starting one cycle after the start. `busy` stays low and no bit is offered.
- R6: A CRC follows the payload when `crc_en`, `ack_en` or `dyn_len` is high. With `crc_long` = 0 it is 8 bits, polynomial x^8+x^2+x+1 (0x07), preset 0xFF. With `crc_long` = 1 it is 16 bits, polynomial x^16+x^12+x^5+1 (0x1021), preset 0xFFFF. It is computed MSB-first over the address, control and payload bits, with no final inversion, and it is sent MSB first.
- R7: A bit advances only on a cycle where `tx_valid` and `bit_en` are both high. While `bit_en` is low, `tx_valid` and `tx_bit` hold. `tx_valid` is low while the next payload byte has not arrived.
- R8: `done` goes high for exactly one cycle, in the cycle after the last bit is consumed. `busy` falls at the same time.
- R9: A `start` while `busy` is high is ignored and leaves the packet in progress unchanged.
- R10: After reset, `busy`, `tx_valid`, `pay_ready`, `done` and `reject` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a packet using the current configuration inputs |
| addr_bytes | input | 3 | Address width in bytes (3 to 5) |
| addr | input | 40 | Address, right aligned |
| ctrl_en | input | 1 | Include the 9-bit control word |
| crc_en | input | 1 | Append a CRC |
| crc_long | input | 1 | 0: 8-bit CRC, 1: 16-bit CRC |
| ack_en | input | 1 | Auto-acknowledge active (forces CRC) |
| dyn_len | input | 1 | Dynamic payload length active (forces CRC) |
| pay_len | input | 6 | Payload length in bytes (1 to 32) |
| pkt_id | input | 2 | Packet identity for the control word |
| no_ack | input | 1 | No-acknowledge flag for the control word |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Framer accepts a payload byte |
| bit_en | input | 1 | Bit strobe from the modulator |
| tx_bit | output | 1 | Current bit |
| tx_valid | output | 1 | `tx_bit` is valid and is consumed on `bit_en` |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle pulse after the last bit |
| reject | output | 1 | One-cycle pulse for a refused start |

## Verification
The checker holds the per-cycle handshake rules on every clock: the bit holds while the strobe is low, ready and valid only appear while busy, done is a single pulse that coincides with busy falling, and reject appears only when idle and only after a start. Whether the stream carries the right preamble phase, address order, control packing, payload order and CRC value can only be shown by the bench's packets, which compare each consumed bit against a stream rebuilt from the requirements. The same holds for the forced-CRC rule and for a start being ignored mid-packet. Random strobe and payload rates exercise pauses in every field.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_ADDR,
      PH_CTRL,
      PH_PAY,
      PH_CRC
   } phase_t;

   localparam int PRE_BITS  = 8;
   localparam int BYTE_BITS = 8;
endpackage

// File: rtl/pf_crc_step.sv
module pf_crc_step #(
   parameter int            W    = 8,
   parameter logic [W-1:0]  POLY = '0
) (
   input  logic [W-1:0] cur,
   input  logic         in_bit,
   output logic [W-1:0] nxt
);
   logic fb;
   assign fb  = in_bit ^ cur[W-1];
   assign nxt = {cur[W-2:0], 1'b0} ^ (fb ? POLY : {W{1'b0}});
endmodule

// File: rtl/pf_pay_buf.sv
module pf_pay_buf #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          want,
   input  logic [DW-1:0] in_data,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic          shift,
   input  logic          drain,
   output logic          out_bit,
   output logic          full
);
   logic [DW-1:0] sh_q;

   assign in_ready = want && !full;
   assign out_bit  = sh_q[DW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
         full <= 1'b0;
      end else if (clr) begin
         full <= 1'b0;
      end else if (in_valid && in_ready) begin
         sh_q <= in_data;
         full <= 1'b1;
      end else if (shift) begin
         sh_q <= {sh_q[DW-2:0], 1'b0};
         if (drain) full <= 1'b0;
      end
   end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
   import pkt_framer_pkg::*;
#(
   parameter int          ADDR_MIN_B = 3,
   parameter int          ADDR_MAX_B = 5,
   parameter int          MAX_PAY    = 32,
   parameter int          LEN_W      = 6,
   parameter int          PID_W      = 2,
   parameter logic [7:0]  POLY8      = 8'h07,
   parameter logic [7:0]  INIT8      = 8'hFF,
   parameter logic [15:0] POLY16     = 16'h1021,
   parameter logic [15:0] INIT16     = 16'hFFFF,
   localparam int         AWB_W      = $clog2(ADDR_MAX_B + 1),
   localparam int         ABITS      = 8 * ADDR_MAX_B
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [AWB_W-1:0] addr_bytes,
   input  logic [ABITS-1:0] addr,
   input  logic             ctrl_en,
   input  logic             crc_en,
   input  logic             crc_long,
   input  logic             ack_en,
   input  logic             dyn_len,
   input  logic [LEN_W-1:0] pay_len,
   input  logic [PID_W-1:0] pkt_id,
   input  logic             no_ack,
   input  logic [7:0]       pay_data,
   input  logic             pay_valid,
   output logic             pay_ready,
   input  logic             bit_en,
   output logic             tx_bit,
   output logic             tx_valid,
   output logic             busy,
   output logic             done,
   output logic             reject
);
   localparam int CTRL_W = LEN_W + PID_W + 1;
   localparam int CNT_W  = $clog2(ABITS + CTRL_W + 17);
   localparam logic [AWB_W-1:0] AMIN = AWB_W'(ADDR_MIN_B);
   localparam logic [AWB_W-1:0] AMAX = AWB_W'(ADDR_MAX_B);
   localparam logic [LEN_W-1:0] LMAX = LEN_W'(MAX_PAY);
   localparam logic [CNT_W-1:0] C_BYTE = CNT_W'(BYTE_BITS);
   localparam logic [CNT_W-1:0] C_CTRL = CNT_W'(CTRL_W);
   localparam logic [CNT_W-1:0] C_PRE  = CNT_W'(PRE_BITS);
   localparam logic [CNT_W-1:0] C_C16  = CNT_W'(16);

   // elaboration-time parameter checks
   generate
      if (ADDR_MIN_B < 1 || ADDR_MAX_B < ADDR_MIN_B) begin : g_bad_aw
         $error("pkt_framer: address width range is empty");
      end
      if (MAX_PAY < 1 || MAX_PAY >= (1 << LEN_W)) begin : g_bad_len
         $error("pkt_framer: MAX_PAY must fit the length field");
      end
   endgenerate

   phase_t             phase;
   logic [CNT_W-1:0]   cnt;
   logic [ABITS-1:0]   ash;
   logic [CTRL_W-1:0]  ctl;
   logic [AWB_W-1:0]   aw_q;
   logic [LEN_W-1:0]   len_q, got, sent;
   logic               with_ctrl, with_crc, long_q, pre_bit;
   logic [15:0]        crc_q;
   logic               done_q, rej_q;

   logic               acc, ok, adv, last, cur_bit, pay_bit, pay_full;
   logic [AWB_W-1:0]   gap;
   logic [ABITS-1:0]   addr_al;
   logic [7:0]         nxt8;
   logic [15:0]        nxt16;

   assign acc     = start && (phase == PH_IDLE);
   assign ok      = (addr_bytes >= AMIN) && (addr_bytes <= AMAX) &&
                    (pay_len != '0) && (pay_len <= LMAX);
   assign gap     = AMAX - addr_bytes;
   assign addr_al = addr << {gap, 3'b000};

   assign busy     = (phase != PH_IDLE);
   assign tx_valid = busy && ((phase != PH_PAY) || pay_full);
   assign adv      = tx_valid && bit_en;
   assign last     = (cnt == CNT_W'(1));
   assign done     = done_q;
   assign reject   = rej_q;
   assign tx_bit   = cur_bit;

   always_comb begin
      case (phase)
         PH_PRE:  cur_bit = pre_bit ^ cnt[0];
         PH_ADDR: cur_bit = ash[ABITS-1];
         PH_CTRL: cur_bit = ctl[CTRL_W-1];
         PH_PAY:  cur_bit = pay_bit;
         PH_CRC:  cur_bit = long_q ? crc_q[15] : crc_q[7];
         default: cur_bit = 1'b0;
      endcase
   end

   pf_crc_step #(.W(8), .POLY(POLY8)) u_crc8 (
      .cur(crc_q[7:0]), .in_bit(cur_bit), .nxt(nxt8)
   );
   pf_crc_step #(.W(16), .POLY(POLY16)) u_crc16 (
      .cur(crc_q), .in_bit(cur_bit), .nxt(nxt16)
   );

   pf_pay_buf #(.DW(8)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(acc),
      .want(busy && (got != len_q)),
      .in_data(pay_data), .in_valid(pay_valid), .in_ready(pay_ready),
      .shift(adv && (phase == PH_PAY)), .drain(last),
      .out_bit(pay_bit), .full(pay_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got <= '0;
      end else if (acc) begin
         got <= '0;
      end else if (pay_valid && pay_ready) begin
         got <= got + LEN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         ash       <= '0;
         ctl       <= '0;
         aw_q      <= '0;
         len_q     <= '0;
         sent      <= '0;
         with_ctrl <= 1'b0;
         with_crc  <= 1'b0;
         long_q    <= 1'b0;
         pre_bit   <= 1'b0;
         crc_q     <= '0;
         done_q    <= 1'b0;
         rej_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         rej_q  <= 1'b0;
         if (acc) begin
            if (ok) begin
               phase     <= PH_PRE;
               cnt       <= C_PRE;
               ash       <= addr_al;
               pre_bit   <= addr_al[ABITS-1];
               ctl       <= {pay_len, pkt_id, no_ack};
               aw_q      <= addr_bytes;
               len_q     <= pay_len;
               sent      <= '0;
               with_ctrl <= ctrl_en;
               with_crc  <= crc_en | ack_en | dyn_len;
               long_q    <= crc_long;
               crc_q     <= crc_long ? INIT16 : {8'h00, INIT8};
            end else begin
               rej_q <= 1'b1;
            end
         end else if (adv) begin
            cnt <= cnt - CNT_W'(1);
            if (phase == PH_ADDR || phase == PH_CTRL || phase == PH_PAY) begin
               crc_q <= long_q ? nxt16 : {8'h00, nxt8};
            end
            case (phase)
               PH_PRE: begin
                  if (last) begin
                     phase <= PH_ADDR;
                     cnt   <= CNT_W'({aw_q, 3'b000});
                  end
               end
               PH_ADDR: begin
                  ash <= {ash[ABITS-2:0], 1'b0};
                  if (last) begin
                     phase <= with_ctrl ? PH_CTRL : PH_PAY;
                     cnt   <= with_ctrl ? C_CTRL : C_BYTE;
                  end
               end
               PH_CTRL: begin
                  ctl <= {ctl[CTRL_W-2:0], 1'b0};
                  if (last) begin
                     phase <= PH_PAY;
                     cnt   <= C_BYTE;
                  end
               end
               PH_PAY: begin
                  if (last) begin
                     sent <= sent + LEN_W'(1);
                     if (sent == len_q - LEN_W'(1)) begin
                        if (with_crc) begin
                           phase <= PH_CRC;
                           cnt   <= long_q ? C_C16 : C_BYTE;
                        end else begin
                           phase  <= PH_IDLE;
                           done_q <= 1'b1;
                        end
                     end else begin
                        cnt <= C_BYTE;
                     end
                  end
               end
               PH_CRC: begin
                  crc_q <= {crc_q[14:0], 1'b0};
                  if (last) begin
                     phase  <= PH_IDLE;
                     done_q <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic bit_en,
   input logic tx_bit,
   input logic tx_valid,
   input logic busy,
   input logic done,
   input logic reject,
   input logic pay_ready
);
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R8
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                   // R8
   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);                                             // R8
   AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> !busy);                                                 // R5
   AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> $past(start));                                          // R5
   AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> busy);                                                // R7
   AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !bit_en) |=> (tx_valid && $stable(tx_bit)));          // R7
   AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pay_ready |-> busy);                                               // R4
endmodule

bind pkt_framer pkt_framer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .bit_en(bit_en),
   .tx_bit(tx_bit), .tx_valid(tx_valid), .busy(busy), .done(done),
   .reject(reject), .pay_ready(pay_ready)
);

// File: tb/sim_pkt_framer.sv
module sim_pkt_framer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        start, ctrl_en, crc_en, crc_long, ack_en, dyn_len, no_ack;
   logic [2:0]  addr_bytes;
   logic [39:0] addr;
   logic [5:0]  pay_len;
   logic [1:0]  pkt_id;
   logic [7:0]  pay_data;
   logic        pay_valid, pay_ready, bit_en, tx_bit, tx_valid, busy, done, reject;

   always #5 clk = ~clk;

   pkt_framer u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .addr_bytes(addr_bytes), .addr(addr),
      .ctrl_en(ctrl_en), .crc_en(crc_en), .crc_long(crc_long), .ack_en(ack_en),
      .dyn_len(dyn_len), .pay_len(pay_len), .pkt_id(pkt_id), .no_ack(no_ack),
      .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
      .bit_en(bit_en), .tx_bit(tx_bit), .tx_valid(tx_valid), .busy(busy),
      .done(done), .reject(reject)
   );

   int   n_chk = 0;
   int   n_fail = 0;
   bit   exp_b [0:511];
   int   exp_n;
   logic [7:0] pl [0:31];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic void push(input bit b);
      exp_b[exp_n] = b;
      exp_n++;
   endfunction

   // expected stream from the requirements
   function automatic void build(input int aw, input logic [39:0] a, input bit ce,
                                 input bit crc_on, input bit lng, input int len,
                                 input logic [1:0] pid, input bit na);
      logic [15:0] c;
      bit          d [0:400];
      int          nd = 0;
      bit          fb;
      exp_n = 0;
      for (int i = 8 * aw - 1; i >= 0; i--) begin d[nd] = a[i]; nd++; end
      if (ce) begin
         for (int i = 5; i >= 0; i--) begin d[nd] = len[i]; nd++; end
         d[nd] = pid[1]; nd++;
         d[nd] = pid[0]; nd++;
         d[nd] = na; nd++;
      end
      for (int k = 0; k < len; k++)
         for (int i = 7; i >= 0; i--) begin d[nd] = pl[k][i]; nd++; end
      for (int i = 0; i < 8; i++) push(d[0] ^ i[0]);   // R1 alternating preamble
      for (int i = 0; i < nd; i++) push(d[i]);
      if (crc_on) begin
         c = lng ? 16'hFFFF : 16'h00FF;
         for (int i = 0; i < nd; i++) begin
            if (lng) begin
               fb = d[i] ^ c[15];
               c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end else begin
               fb = d[i] ^ c[7];
               c[7:0] = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
            end
         end
         for (int i = (lng ? 15 : 7); i >= 0; i--) push(c[i]);
      end
   endfunction

   task automatic run_pkt(input int aw, input logic [39:0] a, input bit ce, input bit ec,
                          input bit lng, input bit ak, input bit dl, input int len,
                          input logic [1:0] pid, input bit na, input int brate,
                          input int prate, input bit inject);
      int idx = 0, bi = 0, mism = 0, cyc = 0, bad_idx = -1;
      bit got_done = 0, fired = 0, hold = 0, prev = 0, be, pv;
      for (int k = 0; k < 32; k++) pl[k] = 8'($urandom);
      build(aw, a, ce, ec | ak | dl, lng, len, pid, na);
      @(negedge clk);
      addr_bytes = 3'(aw); addr = a; ctrl_en = ce; crc_en = ec; crc_long = lng;
      ack_en = ak; dyn_len = dl; pay_len = 6'(len); pkt_id = pid; no_ack = na;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!got_done && cyc < 20000) begin
         if (done) begin
            got_done = 1;
         end else begin
            if (hold && (!tx_valid || tx_bit != prev)) mism++;     // R7 hold
            be   = ($urandom % 100) < brate;
            hold = tx_valid && !be;
            prev = tx_bit;
            if (be && tx_valid) begin
               if (idx >= exp_n || tx_bit != exp_b[idx]) begin
                  mism++;
                  if (bad_idx < 0) bad_idx = idx;
               end
               idx++;
            end
            bit_en = be;
            start  = inject && !fired && idx == 20;              // R9
            if (start) begin
               fired = 1;
               pay_len = 6'd1;
               ctrl_en = ~ce;
            end
            pv = (bi < len) && (($urandom % 100) < prate);
            pay_valid = pv;
            pay_data  = pv ? pl[bi] : 8'($urandom);
            if (pv && pay_ready) bi++;
            @(negedge clk);
            cyc++;
         end
      end
      bit_en = 0; pay_valid = 0; start = 0;
      check(mism == 0, "R1 R2 R3 R4 R6 R7 R9 stream", bad_idx, -1);
      check(got_done, "R8 done seen", int'(got_done), 1);
      check(idx == exp_n, "R8 bit count", idx, exp_n);
      check(bi == len, "R4 bytes taken", bi, len);
      check(!busy, "R8 idle after done", int'(busy), 0);
   endtask

   task automatic run_rej(input int aw, input int len, input string tag);
      @(negedge clk);
      addr_bytes = 3'(aw); pay_len = 6'(len); addr = 40'hA5A5A5A5A5;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(reject && !busy && !tx_valid && !pay_ready, tag, int'(reject), 1);
      @(negedge clk);
      check(!reject && !busy, tag, int'(reject), 0);
   endtask

   initial begin
      #1500000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] r;
      void'($urandom(32'd1234));
      rst_n = 0; start = 0; bit_en = 0; pay_valid = 0; pay_data = 0;
      addr_bytes = 3'd5; addr = '0; ctrl_en = 0; crc_en = 0; crc_long = 0;
      ack_en = 0; dyn_len = 0; pay_len = 6'd1; pkt_id = 0; no_ack = 0;
      repeat (3) @(negedge clk);
      check(!busy && !tx_valid && !pay_ready && !done && !reject, "R10 reset idle",
            int'({busy, tx_valid, pay_ready, done, reject}), 0);
      rst_n = 1;
      @(negedge clk);
      check(!busy && !tx_valid && !pay_ready && !done && !reject, "R10 after release",
            int'({busy, tx_valid, pay_ready, done, reject}), 0);

      // directed corners
      run_pkt(5, 40'hC1_2345_6789, 1, 1, 0, 0, 0, 1, 2'b10, 1, 100, 100, 0); // R1 first bit 1
      run_pkt(3, 40'h00_0012_3456, 0, 0, 0, 0, 0, 4, 2'b01, 0, 100, 100, 0); // R1 first bit 0, R6 no crc
      run_pkt(4, 40'h00_8000_0001, 1, 0, 1, 1, 0, 32, 2'b11, 0, 70, 60, 0);  // R6 forced by ack, long
      run_pkt(5, 40'h7F_FFFF_FFFE, 1, 0, 0, 0, 1, 7, 2'b00, 1, 50, 20, 0);   // R6 forced by dyn, short
      run_pkt(3, 40'h00_00AB_CDEF, 0, 1, 1, 0, 0, 3, 2'b01, 0, 100, 5, 0);   // R7 payload starvation
      run_pkt(5, 40'hE7_E7E7_E7E7, 1, 1, 0, 0, 0, 5, 2'b10, 0, 40, 80, 1);   // R9 start while busy

      // refusals
      run_rej(5, 0, "R5 length zero");
      run_rej(5, 33, "R5 length 33");
      run_rej(5, 63, "R5 length 63");
      run_rej(2, 4, "R2 width 2");
      run_rej(6, 4, "R2 width 6");

      // constrained random
      for (int n = 0; n < 16; n++) begin
         r = {$urandom, $urandom};
         run_pkt(3 + int'($urandom % 3), r[39:0], 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1 + int'($urandom % 32),
                 2'($urandom), 1'($urandom), 20 + int'($urandom % 81),
                 10 + int'($urandom % 91), 1'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule